// File: doc/BRIEF.md
# POST Code Snoop Capture FIFO

This block listens to host I/O write cycles and keeps the bytes that the host writes to one or two programmable port addresses. Each host write arrives as a single-cycle strobe with a 16-bit base address, a four-bit byte-enable mask and a 32-bit data word. Byte lane k lives at address base+k. Every matching lane becomes its own entry in a 16-deep byte FIFO, and lanes are stored in ascending address order. A management CPU uses a small byte-wide register port to set the two match addresses and the control bits, to read status, and to pop captured bytes.

Each FIFO entry carries one tag bit. In normal mode the tag tells which of the two ports matched. In double-word mode only the first address is used, and a window of four consecutive bytes starting there is captured. The tag then marks byte 0 of each 32-bit code, so software can split the byte stream back into words.

A level-change detector on the host reset input sets a sticky flag that the CPU clears by writing 1 to it. A registered interrupt reports pending data and host-reset changes, each under its own enable bit.

Top module: `postcode_snoop`

## Requirements
- R1: After a synchronous active-low reset, all registers read 0, the FIFO is empty, the overflow flag is clear and `irq` is low.
- R2: In normal mode, a byte at address A is captured with tag 0 when control bit 7 is set and A equals port address 1. Failing that, it is captured with tag 1 when control bit 6 is set and A equals port address 2. Any other byte, and any byte at a port whose enable bit is clear, is not captured.
- R3: In one strobe, each lane k with `snp_be[k]` set carries the byte `snp_data[8k+7:8k]` at address base+k. Matching lanes are stored as separate entries in ascending lane order.
- R4: A read of offset 0x00 returns the head byte and pops it. A read of offset 0x00 with the FIFO empty returns 0 and removes nothing.
- R5: A read of offset 0x02 returns bit 7 = head valid, bit 5 = overflow, bit 0 = tag of the head entry (0 when empty), and 0 in all other bits.
- R6: Control bit 2 selects double-word mode. In this mode, bytes at port address 1 plus offsets 0 to 3 are captured whatever the values of bits 7 and 6. Port address 2 is ignored. The tag is 1 only on the byte at offset 0.
- R7: The FIFO holds 16 entries. Bytes that do not fit are dropped in lane order, after the earlier lanes of the same strobe are stored, and the overflow flag is set. A read of offset 0x02 while the FIFO is empty returns the flag and then clears it.
- R8: Offset 0x06 bit 6 is set whenever `host_rst_lvl` differs from its value on the previous clock. Writing 1 to that bit clears it. If a change and a clear happen in the same cycle, the flag stays set.
- R9: `irq` is registered. One clock after the state, it equals (control bit 3 and FIFO not empty) or (control bit 4 and host-reset flag set).
- R10: A capture and a pop in the same cycle both take effect. With a full FIFO, that capture is stored and the overflow flag stays clear.
- R11: Register offsets are 0x00 data, 0x02 status, 0x04 control, 0x06 host-reset status, 0x10/0x12 port 1 low/high, 0x14/0x16 port 2 low/high. Control and port registers read back what was written. Read data appears on `reg_rdata` one clock after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snp_valid | input | 1 | Host write strobe, one cycle per write |
| snp_addr | input | 16 | Address of byte lane 0 |
| snp_be | input | 4 | Byte-lane enables of the write |
| snp_data | input | 32 | Write data, lane k in bits 8k+7:8k |
| host_rst_lvl | input | 1 | Host reset level, synchronous to clk |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one clock after a read |
| irq | output | 1 | Registered interrupt level |

## Verification
The hardest states to reach are where FIFO occupancy meets a multi-lane strobe. A four-lane write into a nearly full FIFO must keep the lower lanes and drop the upper ones. A capture landing in the same cycle as a pop of a full FIFO must lose nothing. The stimulus fills the FIFO to exact levels with single-byte writes and then fires a wide double-word write or a combined capture-and-pop. Random writes around both port addresses, with random pops and mode changes, are compared against a bench queue model. The same-cycle change-and-clear of the host-reset flag is driven directly.

// File: rtl/postcode_snoop_pkg.sv
// Shared constants and types for the POST code snoop block.
// Assumes byte-wide register offsets fit in five bits.
package postcode_snoop_pkg;

    // register offsets (byte addresses)
    localparam int OFS_DATA = 'h00;
    localparam int OFS_STAT = 'h02;
    localparam int OFS_CTRL = 'h04;
    localparam int OFS_HRST = 'h06;
    localparam int OFS_P1L  = 'h10;
    localparam int OFS_P1H  = 'h12;
    localparam int OFS_P2L  = 'h14;
    localparam int OFS_P2H  = 'h16;

    // control bit positions
    localparam int CTL_P1EN  = 7;
    localparam int CTL_P2EN  = 6;
    localparam int CTL_HRIE  = 4;
    localparam int CTL_RDYIE = 3;
    localparam int CTL_DWORD = 2;

    // status bit positions
    localparam int ST_VALID = 7;
    localparam int ST_OVF   = 5;
    localparam int ST_TAG   = 0;
    localparam int HR_CHG   = 6;

    // bytes in one double-word code
    localparam int DW_BYTES = 4;

    typedef struct packed {
        logic       tag;
        logic [7:0] data;
    } code_byte_t;

endpackage

// File: rtl/postcode_lane_match.sv
// Per-lane address decoder: decides for each byte lane of a host write
// whether it is captured and with which tag.
// Assumes lane k sits at base + k, with the address wrapping at 2**AW.
module postcode_lane_match
    import postcode_snoop_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LANES = 4
) (
    input  logic [AW-1:0]    base,
    input  logic             strobe,
    input  logic [LANES-1:0] be,
    input  logic [AW-1:0]    port1,
    input  logic [AW-1:0]    port2,
    input  logic             en1,
    input  logic             en2,
    input  logic             dword,
    output logic [LANES-1:0] hit,
    output logic [LANES-1:0] tag
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [AW-1:0] lane_addr;
        logic [AW-1:0] offs;
        logic          m1;
        logic          m2;

        assign lane_addr = base + AW'(k);
        assign offs      = lane_addr - port1;
        assign m1        = en1 && (lane_addr == port1);
        assign m2        = en2 && (lane_addr == port2);

        // decide capture and tag for this lane
        always_comb begin
            if (dword) begin
                hit[k] = strobe && be[k] && (offs < AW'(DW_BYTES));
                tag[k] = (offs == '0);
            end else begin
                hit[k] = strobe && be[k] && (m1 || m2);
                tag[k] = !m1;
            end
        end
    end

endmodule

// File: rtl/postcode_fifo.sv
// Tagged byte FIFO taking up to LANES pushes and one pop per cycle.
// Pushes are stored in lane order. Lanes beyond the free room are
// dropped and flagged. Assumes DEPTH is a power of two and that pop is
// only raised when the FIFO is not empty.
module postcode_fifo #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    parameter int W     = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          push,
    input  logic [LANES-1:0][W-1:0]   push_data,
    input  logic                      pop,
    output logic [W-1:0]              head,
    output logic                      empty,
    output logic                      drop
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]              mem [DEPTH];
    logic [PW-1:0]             rd_ptr;
    logic [CW-1:0]             count;
    logic [LANES-1:0]          we;
    logic [LANES-1:0][PW-1:0]  wpos;
    logic [CW-1:0]             n_acc;
    int                        room;
    int                        rank;

    // assign write slots to pushing lanes in order, drop what does not fit
    always_comb begin
        room = DEPTH - int'(count) + (pop ? 1 : 0);
        rank = 0;
        we   = '0;
        wpos = '0;
        drop = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (push[k]) begin
                if (rank < room) begin
                    we[k]   = 1'b1;
                    wpos[k] = rd_ptr + PW'(count) + PW'(rank);
                    rank    = rank + 1;
                end else begin
                    drop = 1'b1;
                end
            end
        end
        n_acc = CW'(rank);
    end

    // store accepted bytes
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (we[k]) mem[wpos[k]] <= push_data[k];
        end
    end

    // advance read pointer and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count - CW'(pop) + n_acc;
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r4_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !pop && push != '0) |-> drop);

    a_r10_full_swap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && pop && $countones(push) == 1) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/postcode_hrst_detect.sv
// Sticky detector for any level change of the host reset input.
// Assumes the input is already synchronous to clk. A change and a clear
// in the same cycle leave the flag set.
module postcode_hrst_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic flag
);

    logic prev;

    // remember last level and raise the flag on a difference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            flag <= 1'b0;
        end else begin
            prev <= lvl;
            if (lvl != prev)  flag <= 1'b1;
            else if (clr)     flag <= 1'b0;
        end
    end

    a_r8_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != prev) |=> flag);

    a_r8_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/postcode_snoop.sv
// POST code snoop capture: decodes host writes against two port
// addresses, queues tagged bytes, tracks host-reset changes and offers a
// byte-wide register port with one-cycle read latency.
// Assumes all inputs are synchronous to clk.
module postcode_snoop
    import postcode_snoop_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int REG_AW     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snp_valid,
    input  logic [ADDR_W-1:0]    snp_addr,
    input  logic [LANES-1:0]     snp_be,
    input  logic [8*LANES-1:0]   snp_data,
    input  logic                 host_rst_lvl,
    input  logic                 reg_en,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 irq
);

    localparam logic [REG_AW-1:0] A_DATA = REG_AW'(OFS_DATA);
    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
    localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
    localparam logic [REG_AW-1:0] A_HRST = REG_AW'(OFS_HRST);
    localparam logic [REG_AW-1:0] A_P1L  = REG_AW'(OFS_P1L);
    localparam logic [REG_AW-1:0] A_P1H  = REG_AW'(OFS_P1H);
    localparam logic [REG_AW-1:0] A_P2L  = REG_AW'(OFS_P2L);
    localparam logic [REG_AW-1:0] A_P2H  = REG_AW'(OFS_P2H);

    logic [7:0]                  ctrl;
    logic [ADDR_W-1:0]           port1;
    logic [ADDR_W-1:0]           port2;
    logic                        ovf;
    logic                        rd_acc;
    logic                        wr_acc;
    logic [LANES-1:0]            lane_hit;
    logic [LANES-1:0]            lane_tag;
    logic [LANES-1:0][8:0]       lane_ent;
    code_byte_t                  head;
    logic                        empty;
    logic                        drop;
    logic                        pop;
    logic                        hr_clr;
    logic                        hr_flag;
    logic [7:0]                  stat;
    logic [7:0]                  rd_mux;

    assign rd_acc = reg_en && !reg_wr;
    assign wr_acc = reg_en && reg_wr;
    assign pop    = rd_acc && (reg_addr == A_DATA) && !empty;
    assign hr_clr = wr_acc && (reg_addr == A_HRST) && reg_wdata[HR_CHG];

    postcode_lane_match #(.AW(ADDR_W), .LANES(LANES)) u_match (
        .base   (snp_addr),
        .strobe (snp_valid),
        .be     (snp_be),
        .port1  (port1),
        .port2  (port2),
        .en1    (ctrl[CTL_P1EN]),
        .en2    (ctrl[CTL_P2EN]),
        .dword  (ctrl[CTL_DWORD]),
        .hit    (lane_hit),
        .tag    (lane_tag)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_ent
        assign lane_ent[k] = {lane_tag[k], snp_data[8*k +: 8]};
    end

    postcode_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES), .W(9)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (lane_hit),
        .push_data (lane_ent),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .drop      (drop)
    );

    postcode_hrst_detect u_hrst (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (host_rst_lvl),
        .clr  (hr_clr),
        .flag (hr_flag)
    );

    // assemble FIFO status byte
    always_comb begin
        stat           = '0;
        stat[ST_VALID] = !empty;
        stat[ST_OVF]   = ovf;
        stat[ST_TAG]   = !empty && head.tag;
    end

    // select read data by offset
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_DATA:  rd_mux = empty ? 8'h00 : head.data;
            A_STAT:  rd_mux = stat;
            A_CTRL:  rd_mux = ctrl;
            A_HRST:  rd_mux = 8'(hr_flag) << HR_CHG;
            A_P1L:   rd_mux = port1[7:0];
            A_P1H:   rd_mux = port1[ADDR_W-1:8];
            A_P2L:   rd_mux = port2[7:0];
            A_P2H:   rd_mux = port2[ADDR_W-1:8];
            default: rd_mux = '0;
        endcase
    end

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            port1 <= '0;
            port2 <= '0;
        end else if (wr_acc) begin
            case (reg_addr)
                A_CTRL: ctrl               <= reg_wdata;
                A_P1L:  port1[7:0]         <= reg_wdata;
                A_P1H:  port1[ADDR_W-1:8]  <= reg_wdata;
                A_P2L:  port2[7:0]         <= reg_wdata;
                A_P2H:  port2[ADDR_W-1:8]  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_acc) reg_rdata <= rd_mux;
    end

    // sticky overflow, cleared by a status read of an empty FIFO
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ovf <= 1'b0;
        else if (drop)                                 ovf <= 1'b1;
        else if (rd_acc && reg_addr == A_STAT && empty) ovf <= 1'b0;
    end

    // registered interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (ctrl[CTL_RDYIE] && !empty) || (ctrl[CTL_HRIE] && hr_flag);
    end

    a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CTL_RDYIE] && !ctrl[CTL_HRIE]) |=> !irq);

    a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && reg_addr == A_DATA && empty) |=> (reg_rdata == 8'h00));

    a_r9_data_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CTL_RDYIE] && !empty) |=> irq);

endmodule

// File: tb/postcode_snoop_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic
// checked against a queue model built from the requirements.
module postcode_snoop_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 1'b0;
    logic [15:0] snp_addr = '0;
    logic [3:0]  snp_be = '0;
    logic [31:0] snp_data = '0;
    logic        host_rst_lvl = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    int          mq[$];
    bit          m_ovf = 1'b0;
    bit          m_hr = 1'b0;
    logic [7:0]  m_ctrl = '0;
    logic [15:0] m_p1 = '0;
    logic [15:0] m_p2 = '0;

    postcode_snoop u_dut (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_be(snp_be), .snp_data(snp_data), .host_rst_lvl(host_rst_lvl),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // model of the capture rule, per requirement R2/R3/R6/R7
    task automatic model_push(logic [15:0] base, logic [3:0] be, logic [31:0] d);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] a;
            logic [15:0] off;
            int ent;
            bit take;
            a = base + 16'(k);
            off = a - m_p1;
            take = 1'b0;
            ent = 0;
            if (be[k]) begin
                if (m_ctrl[2]) begin
                    if (off < 16'd4) begin take = 1; ent = ((off == 0) ? 256 : 0) | int'(d[8*k +: 8]); end
                end else if (m_ctrl[7] && a == m_p1) begin
                    take = 1; ent = int'(d[8*k +: 8]);
                end else if (m_ctrl[6] && a == m_p2) begin
                    take = 1; ent = 256 | int'(d[8*k +: 8]);
                end
            end
            if (take) begin
                if (mq.size() >= 16) m_ovf = 1'b1;
                else mq.push_back(ent);
            end
        end
    endtask

    task automatic snoop(logic [15:0] base, logic [3:0] be, logic [31:0] d);
        snp_valid = 1'b1; snp_addr = base; snp_be = be; snp_data = d;
        model_push(base, be, d);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic reg_write(int ofs, logic [7:0] v);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 5'(ofs); reg_wdata = v;
        case (ofs)
            'h04: m_ctrl = v;
            'h10: m_p1[7:0] = v;
            'h12: m_p1[15:8] = v;
            'h14: m_p2[7:0] = v;
            'h16: m_p2[15:8] = v;
            'h06: if (v[6]) m_hr = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(int ofs, output int v);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 5'(ofs);
        @(negedge clk);
        reg_en = 1'b0;
        v = int'(reg_rdata);
    endtask

    function automatic int exp_stat();
        if (mq.size() == 0) return m_ovf ? 'h20 : 0;
        return 'h80 | (m_ovf ? 'h20 : 0) | (mq[0] >> 8);
    endfunction

    // status then data read, both compared to the model
    task automatic pop_check(string req);
        int v;
        int e;
        reg_read('h02, v);
        check({req, " status"}, v, exp_stat());
        if (mq.size() == 0) m_ovf = 1'b0;
        reg_read('h00, v);
        e = (mq.size() == 0) ? 0 : (mq[0] & 'hFF);
        if (mq.size() != 0) void'(mq.pop_front());
        check({req, " data"}, v, e);
    endtask

    task automatic drain(string req);
        while (mq.size() > 0) pop_check(req);
        pop_check(req);
    endtask

    task automatic irq_check(string req);
        @(negedge clk);
        check(req, int'(irq), int'((m_ctrl[3] && mq.size() > 0) || (m_ctrl[4] && m_hr)));
    endtask

    task automatic configure(logic [15:0] p1, logic [15:0] p2, logic [7:0] c);
        reg_write('h10, p1[7:0]); reg_write('h12, p1[15:8]);
        reg_write('h14, p2[7:0]); reg_write('h16, p2[15:8]);
        reg_write('h04, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0123);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", int'(irq), 0);
        reg_read('h02, v); check("R1 status", v, 0);
        reg_read('h04, v); check("R1 ctrl", v, 0);
        reg_read('h06, v); check("R1 hrst", v, 0);
        reg_read('h10, v); check("R1 port1", v, 0);
        reg_read('h00, v); check("R1 data empty", v, 0);

        // R11 register map readback
        configure(16'h0080, 16'h0081, 8'hC8);
        reg_read('h10, v); check("R11 p1 low", v, 'h80);
        reg_read('h12, v); check("R11 p1 high", v, 'h00);
        reg_read('h14, v); check("R11 p2 low", v, 'h81);
        reg_read('h04, v); check("R11 ctrl", v, 'hC8);

        // R2 single bytes on each port, other addresses ignored
        snoop(16'h0080, 4'b0001, 32'h0000_00A5);
        irq_check("R9 irq data");
        snoop(16'h0081, 4'b0001, 32'h0000_005A);
        snoop(16'h0082, 4'b0001, 32'h0000_0077);
        snoop(16'h0180, 4'b0001, 32'h0000_0066);
        pop_check("R2");
        pop_check("R2");
        pop_check("R2 ignored");
        irq_check("R9 irq empty");

        // R2 disabled port is not captured
        reg_write('h04, 8'h48);
        snoop(16'h0080, 4'b0001, 32'h0000_0011);
        reg_read('h02, v); check("R2 disabled port", v, exp_stat());

        // R3 wide write, lanes in ascending order
        reg_write('h04, 8'hC8);
        snoop(16'h007F, 4'b1111, 32'h4433_2211);
        snoop(16'h0080, 4'b0110, 32'hDDCC_BBAA);
        drain("R3");

        // R6 double-word mode
        reg_write('h04, 8'h0C);
        snoop(16'h0080, 4'b1111, 32'h4433_2211);
        snoop(16'h0082, 4'b0011, 32'h0000_BEEF);
        snoop(16'h007E, 4'b1111, 32'h9988_7766);
        snoop(16'h0084, 4'b0001, 32'h0000_0055);
        drain("R6");

        // R7 overflow with a wide write across the boundary
        for (int i = 0; i < 14; i++) snoop(16'h0083, 4'b0001, 32'(i));
        snoop(16'h0080, 4'b1111, 32'hF4F3_F2F1);
        reg_read('h02, v); check("R7 full ovf", v, exp_stat());
        drain("R7");
        reg_read('h02, v); check("R7 ovf cleared", v, 0);

        // R10 capture with pop on a full FIFO
        for (int i = 0; i < 16; i++) snoop(16'h0081, 4'b0001, 32'(8'h30 + i));
        snp_valid = 1'b1; snp_addr = 16'h0080; snp_be = 4'b0001; snp_data = 32'h0000_00E7;
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 5'h00;
        @(negedge clk);
        snp_valid = 1'b0; reg_en = 1'b0;
        check("R10 popped", int'(reg_rdata), mq[0] & 'hFF);
        void'(mq.pop_front());
        mq.push_back(256 | 'hE7);
        reg_read('h02, v); check("R10 no ovf", v, exp_stat());
        drain("R10");

        // R8 host reset flag
        reg_write('h04, 8'h10);
        host_rst_lvl = 1'b1; m_hr = 1'b1;
        @(negedge clk);
        reg_read('h06, v); check("R8 flag set", v, 'h40);
        irq_check("R9 irq hrst");
        reg_write('h06, 8'h40);
        reg_read('h06, v); check("R8 w1c", v, 0);
        irq_check("R9 irq hrst clear");
        host_rst_lvl = 1'b0;
        reg_write('h06, 8'h40);
        m_hr = 1'b1;
        reg_read('h06, v); check("R8 set wins", v, 'h40);
        reg_write('h06, 8'h40);

        // random traffic against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 5) begin
                snoop(16'h007E + 16'($urandom_range(0, 8)), 4'($urandom_range(1, 15)),
                      $urandom());
            end else if (op < 8) begin
                pop_check("R4 random");
            end else if (op == 8) begin
                reg_write('h04, {2'($urandom_range(0, 3)), 3'b001, 1'($urandom_range(0, 1)), 2'b00});
            end else begin
                irq_check("R9 random");
            end
        end
        drain("R5 final");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule